// File: doc/BRIEF.md
# Qualified Event Counter with Sticky Wrap Flag

This block counts one chosen performance event from a vector of single-cycle event pulses. A pulse is counted only when it passes every qualifier that software has switched on. The qualifiers cover the opcode of the retiring instruction (compare under a mask), the current privilege level (one mask bit per level), the instruction address (an inclusive window) and the data address (a second inclusive window). Qualifiers that are switched off do not affect counting.

Software drives the block through a small word-indexed register bus with a write strobe and a combinational read port. One register holds the settings and status, one holds the 32-bit running count, and further registers hold the opcode pattern and the address window bounds. When the count rolls over from all ones to zero, a sticky wrap flag is set. That flag, gated by an enable bit, drives the interrupt line.

Top module: `perf_evt_counter`

Register indices: 0 settings, 1 count, 2 opcode pattern (pattern in bits 7:0, mask in bits 23:16), 3 instruction window low, 4 instruction window high, 5 data window low, 6 data window high. Settings bits: 3:0 event select, 4 count enable, 5 opcode qualifier on, 6 privilege qualifier on, 7 instruction window on, 8 data window on, 9 interrupt enable, 10 wrap flag (write 1 to clear), 15:12 privilege mask.

## Requirements
- R1: After reset every register reads zero and irq is low.
- R2: With count enable set, the count rises by exactly one in each cycle in which the pulse at the selected event index is high and all switched-on qualifiers match. Pulses on other indices are never counted, and nothing is counted while count enable is low.
- R3: The opcode qualifier matches when the opcode and the pattern agree in every bit position where the mask is 1. A mask of zero matches every opcode.
- R4: The privilege qualifier matches when the privilege mask bit indexed by the 2-bit privilege level is 1.
- R5: The instruction window matches when low <= instruction address <= high, inclusive at both bounds.
- R6: The data window matches when low <= data address <= high, inclusive at both bounds.
- R7: A qualifier that is switched off has no effect on counting, whatever its pattern or bounds hold.
- R8: A counted event at count 0xFFFFFFFF leaves the count at 0 and sets the wrap flag (settings bit 10). The flag stays set until software clears it.
- R9: irq is high exactly when the wrap flag and the interrupt enable (settings bit 9) are both 1.
- R10: A software write to the count register takes priority over an increment in the same cycle. The written value is stored.
- R11: Every register reads back what was written to it. Writing 1 to settings bit 10 clears the wrap flag, and writing 0 there leaves the flag unchanged.
- R12: If a wrap and a flag clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_pulse | input | 16 | Event pulses from the core |
| ctx_opcode | input | 8 | Opcode of the retiring instruction |
| ctx_priv | input | 2 | Current privilege level |
| ctx_iaddr | input | 32 | Instruction address |
| ctx_daddr | input | 32 | Data address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the coincidences: a wrap in the same cycle as a software count write, and a wrap in the same cycle as a flag clear. Random counting from zero would never get close to a wrap. Directed sequences therefore preload 0xFFFFFFFF and place the write or the clear on the exact cycle of the counted pulse. For qualifier matches, random sequences draw addresses and bounds from a narrow range, so hits, misses and exact-bound hits all occur often.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_COUNT = 3'd1,
    REG_OPPAT = 3'd2,
    REG_IA_LO = 3'd3,
    REG_IA_HI = 3'd4,
    REG_DA_LO = 3'd5,
    REG_DA_HI = 3'd6
  } reg_idx_e;

  localparam int SEL_W   = 4;
  localparam int RNG_N   = 2;
  localparam int OVF_BIT = 10;
  localparam int MASK_LSB = 16;

  typedef struct packed {
    logic [3:0]       pl_mask;
    logic             rsv11;
    logic             ovf;
    logic             irq_en;
    logic             da_en;
    logic             ia_en;
    logic             pl_en;
    logic             op_en;
    logic             cnt_en;
    logic [SEL_W-1:0] evsel;
  } ctrl_t;

endpackage

// File: rtl/pmc_range_cmp.sv
module pmc_range_cmp #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          ok
);
  function automatic logic inside_win(input logic [AW-1:0] l, input logic [AW-1:0] h,
                                      input logic [AW-1:0] a);
    return (a >= l) && (a <= h);
  endfunction

  assign ok = !en || inside_win(lo, hi, addr);
endmodule

// File: rtl/pmc_filter.sv
module pmc_filter
  import pmc_pkg::*;
#(
  parameter int N_EVT = 16,
  parameter int OP_W  = 8,
  parameter int AW    = 32
) (
  input  ctrl_t          ctrl,
  input  logic [OP_W-1:0] op_pat,
  input  logic [OP_W-1:0] op_mask,
  input  logic [AW-1:0]  rng_lo [RNG_N],
  input  logic [AW-1:0]  rng_hi [RNG_N],
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [OP_W-1:0] opcode,
  input  logic [1:0]     priv,
  input  logic [AW-1:0]  iaddr,
  input  logic [AW-1:0]  daddr,
  output logic           evt_hit,
  output logic           filt_ok
);
  function automatic logic op_agree(input logic [OP_W-1:0] op, input logic [OP_W-1:0] pat,
                                    input logic [OP_W-1:0] msk);
    return (op & msk) == (pat & msk);
  endfunction

  logic [AW-1:0] rng_addr [RNG_N];
  logic          rng_en   [RNG_N];
  logic [RNG_N-1:0] rng_ok;
  logic op_ok, pl_ok;

  assign rng_addr[0] = iaddr;
  assign rng_addr[1] = daddr;
  assign rng_en[0]   = ctrl.ia_en;
  assign rng_en[1]   = ctrl.da_en;

  for (genvar g = 0; g < RNG_N; g++) begin : g_rng
    pmc_range_cmp #(.AW(AW)) cmp_i (
      .en  (rng_en[g]),
      .lo  (rng_lo[g]),
      .hi  (rng_hi[g]),
      .addr(rng_addr[g]),
      .ok  (rng_ok[g])
    );
  end

  assign op_ok = !ctrl.op_en || op_agree(opcode, op_pat, op_mask);
  assign pl_ok = !ctrl.pl_en || ctrl.pl_mask[priv];

  always_comb begin
    evt_hit = 1'b0;
    for (int i = 0; i < N_EVT; i++)
      if (ctrl.evsel == SEL_W'(i)) evt_hit = evt_pulse[i];
  end

  assign filt_ok = op_ok && pl_ok && (&rng_ok);
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 32,
  parameter int OP_W  = 8,
  parameter int AW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            cnt_inc,
  output ctrl_t           ctrl,
  output logic [OP_W-1:0] op_pat,
  output logic [OP_W-1:0] op_mask,
  output logic [AW-1:0]   rng_lo [RNG_N],
  output logic [AW-1:0]   rng_hi [RNG_N],
  output logic [CNT_W-1:0] cnt_q,
  output logic            ovf_q,
  output logic            sw_cnt_wr,
  output logic            ovf_clr,
  output logic            cnt_wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  ctrl_t ctrl_q;
  logic wr_en;

  assign wr_en     = bus_sel && bus_wr;
  assign sw_cnt_wr = wr_en && (bus_addr == REG_COUNT);
  assign ovf_clr   = wr_en && (bus_addr == REG_CTRL) && bus_wdata[OVF_BIT];
  assign cnt_wrap  = cnt_inc && !sw_cnt_wr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      op_pat  <= '0;
      op_mask <= '0;
      for (int i = 0; i < RNG_N; i++) begin
        rng_lo[i] <= '0;
        rng_hi[i] <= '0;
      end
    end else if (wr_en) begin
      case (bus_addr)
        REG_CTRL: begin
          ctrl_q       <= ctrl_t'(bus_wdata[15:0]);
          ctrl_q.ovf   <= 1'b0;
          ctrl_q.rsv11 <= 1'b0;
        end
        REG_OPPAT: begin
          op_pat  <= bus_wdata[OP_W-1:0];
          op_mask <= bus_wdata[MASK_LSB +: OP_W];
        end
        REG_IA_LO: rng_lo[0] <= bus_wdata[AW-1:0];
        REG_IA_HI: rng_hi[0] <= bus_wdata[AW-1:0];
        REG_DA_LO: rng_lo[1] <= bus_wdata[AW-1:0];
        REG_DA_HI: rng_hi[1] <= bus_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (sw_cnt_wr)  cnt_q <= bus_wdata[CNT_W-1:0];
    else if (cnt_inc)    cnt_q <= bump(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (cnt_wrap) ovf_q <= 1'b1;
    else if (ovf_clr)  ovf_q <= 1'b0;
  end

  always_comb begin
    ctrl     = ctrl_q;
    ctrl.ovf = ovf_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL:  bus_rdata = DW'(ctrl);
      REG_COUNT: bus_rdata = DW'(cnt_q);
      REG_OPPAT: begin
        bus_rdata[OP_W-1:0]         = op_pat;
        bus_rdata[MASK_LSB +: OP_W] = op_mask;
      end
      REG_IA_LO: bus_rdata = DW'(rng_lo[0]);
      REG_IA_HI: bus_rdata = DW'(rng_hi[0]);
      REG_DA_LO: bus_rdata = DW'(rng_lo[1]);
      REG_DA_HI: bus_rdata = DW'(rng_hi[1]);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter
  import pmc_pkg::*;
#(
  parameter int N_EVT = 16,
  parameter int OP_W  = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic [OP_W-1:0]  ctx_opcode,
  input  logic [1:0]       ctx_priv,
  input  logic [AW-1:0]    ctx_iaddr,
  input  logic [AW-1:0]    ctx_daddr,
  output logic             irq
);
  ctrl_t           ctrl;
  logic [OP_W-1:0] op_pat, op_mask;
  logic [AW-1:0]   rng_lo [RNG_N];
  logic [AW-1:0]   rng_hi [RNG_N];
  logic [CNT_W-1:0] cnt_q;
  logic ovf_q, sw_cnt_wr, ovf_clr, cnt_wrap;
  logic evt_hit, filt_ok, cnt_inc;

  pmc_filter #(.N_EVT(N_EVT), .OP_W(OP_W), .AW(AW)) filt_i (
    .ctrl     (ctrl),
    .op_pat   (op_pat),
    .op_mask  (op_mask),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .evt_pulse(evt_pulse),
    .opcode   (ctx_opcode),
    .priv     (ctx_priv),
    .iaddr    (ctx_iaddr),
    .daddr    (ctx_daddr),
    .evt_hit  (evt_hit),
    .filt_ok  (filt_ok)
  );

  assign cnt_inc = ctrl.cnt_en && evt_hit && filt_ok;

  pmc_regs #(.DW(DW), .CNT_W(CNT_W), .OP_W(OP_W), .AW(AW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_inc  (cnt_inc),
    .ctrl     (ctrl),
    .op_pat   (op_pat),
    .op_mask  (op_mask),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_q),
    .sw_cnt_wr(sw_cnt_wr),
    .ovf_clr  (ovf_clr),
    .cnt_wrap (cnt_wrap)
  );

  assign irq = ovf_q && ctrl.irq_en;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int CNT_W = 32,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q,
  input logic             cnt_inc,
  input logic             sw_cnt_wr,
  input logic             ovf_clr,
  input logic             evt_hit,
  input logic [DW-1:0]    bus_wdata,
  input logic             irq
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !sw_cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_inc && !sw_cnt_wr) |=> $stable(cnt_q));

  p_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_hit |-> !cnt_inc);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !sw_cnt_wr && cnt_q == TOP) |=> (ovf_q && cnt_q == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_q);

  p_swwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cnt_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(cnt_inc && !sw_cnt_wr && cnt_q == TOP)) |=> !ovf_q);
endmodule

bind perf_evt_counter pmc_checker #(.CNT_W(CNT_W), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_q    (cnt_q),
  .ovf_q    (ovf_q),
  .cnt_inc  (cnt_inc),
  .sw_cnt_wr(sw_cnt_wr),
  .ovf_clr  (ovf_clr),
  .evt_hit  (evt_hit),
  .bus_wdata(bus_wdata),
  .irq      (irq)
);

// File: tb/perf_evt_counter_tb.sv
module perf_evt_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_pulse = '0;
  logic [7:0]  ctx_opcode = '0;
  logic [1:0]  ctx_priv = '0;
  logic [31:0] ctx_iaddr = '0, ctx_daddr = '0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  perf_evt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .ctx_opcode(ctx_opcode), .ctx_priv(ctx_priv),
    .ctx_iaddr(ctx_iaddr), .ctx_daddr(ctx_daddr), .irq(irq)
  );

  // bench-side copy of the programmed settings
  logic [31:0] m_ctrl, m_pat, m_ialo, m_iahi, m_dalo, m_dahi, m_cnt;

  function automatic bit want_count(input logic [15:0] ev, input logic [7:0] op,
                                    input logic [1:0] pl, input logic [31:0] ia,
                                    input logic [31:0] da);
    bit ok;
    logic [7:0] differ;
    ok = m_ctrl[4] && ev[m_ctrl[3:0]];
    differ = (op ^ m_pat[7:0]) & m_pat[23:16];
    if (m_ctrl[5] && differ != 0) ok = 0;
    if (m_ctrl[6] && !m_ctrl[12 + pl]) ok = 0;
    if (m_ctrl[7] && (ia < m_ialo || ia > m_iahi)) ok = 0;
    if (m_ctrl[8] && (da < m_dalo || da > m_dahi)) ok = 0;
    return ok;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic program_all();
    wr(3'd2, m_pat); wr(3'd3, m_ialo); wr(3'd4, m_iahi);
    wr(3'd5, m_dalo); wr(3'd6, m_dahi); wr(3'd1, m_cnt); wr(3'd0, m_ctrl);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R11 readback
    m_pat = 32'h00A5_005A; m_ialo = 32'h1000; m_iahi = 32'h2000;
    m_dalo = 32'h30; m_dahi = 32'h40; m_cnt = 32'h1234_5678;
    m_ctrl = 32'h0000_F3F5;
    program_all();
    rd(3'd2, v); check("R11 oppat", v, m_pat);
    rd(3'd4, v); check("R11 iahi", v, m_iahi);
    rd(3'd5, v); check("R11 dalo", v, m_dalo);
    rd(3'd1, v); check("R11 count", v, m_cnt);
    rd(3'd0, v); check("R11 ctrl", v, 32'h0000_F3F5);

    // R7: all qualifiers off but hostile settings; R2 wrong index never counts
    m_ctrl = 32'h0000_0013; m_cnt = 0; m_pat = 32'h00FF_0000;
    m_ialo = 32'hFFFF_0000; m_iahi = 32'h0; m_dalo = 32'hFFFF_0000; m_dahi = 32'h0;
    program_all();
    @(negedge clk); evt_pulse = 16'h0008; ctx_opcode = 8'h77; ctx_iaddr = 5;
    @(negedge clk); evt_pulse = 16'hFFF7;
    @(negedge clk); evt_pulse = 16'h0;
    rd(3'd1, v); check("R7 off qualifiers count, R2 other index ignored", v, 32'd1);

    // R8/R9/R11/R12 directed wrap sequence
    m_ctrl = 32'h0000_0010; m_cnt = 32'hFFFF_FFFF;
    wr(3'd0, m_ctrl); wr(3'd1, m_cnt);
    @(negedge clk); evt_pulse = 16'h0001;
    @(negedge clk); evt_pulse = 16'h0;
    rd(3'd1, v); check("R8 wrap to zero", v, 32'h0);
    rd(3'd0, v); check("R8 flag set", v[10], 1'b1);
    check("R9 irq off without enable", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0000_0210);
    rd(3'd0, v); check("R11 write 0 keeps flag", v[10], 1'b1);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0000_0610);
    rd(3'd0, v); check("R11 write 1 clears flag", v[10], 1'b0);
    check("R9 irq drops", {31'b0, irq}, 32'h0);
    // R12 clear coincident with wrap
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'h0000_0610; evt_pulse = 16'h0001;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_pulse = 0;
    rd(3'd0, v); check("R12 set beats clear", v[10], 1'b1);
    // R10 write coincident with increment
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'd500; evt_pulse = 16'h0001;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_pulse = 0;
    rd(3'd1, v); check("R10 write wins", v, 32'd500);
    wr(3'd0, 32'h0000_0400);

    // Count enable off: R2
    m_ctrl = 32'h0; wr(3'd0, m_ctrl); wr(3'd1, 32'd0);
    @(negedge clk); evt_pulse = 16'hFFFF;
    @(negedge clk); evt_pulse = 0;
    rd(3'd1, v); check("R2 disabled no count", v, 32'd0);

    // Random qualified counting: R2 R3 R4 R5 R6 R7
    for (int cfg = 0; cfg < 24; cfg++) begin
      m_ctrl = {16'h0, 4'($urandom), 3'b0, 5'($urandom) | 5'h01, 4'($urandom_range(0, 3))};
      m_ctrl[4] = 1'b1;
      m_pat = {8'h0, 8'($urandom) & 8'h0F, 8'h0, 8'($urandom)};
      if (cfg % 5 == 0) m_pat[23:16] = 8'h0;
      m_ialo = $urandom_range(0, 30); m_iahi = m_ialo + $urandom_range(0, 30);
      m_dalo = $urandom_range(0, 30); m_dahi = m_dalo + $urandom_range(0, 30);
      m_cnt = $urandom;
      program_all();
      @(negedge clk); bus_addr = 3'd1;
      for (int c = 0; c < 60; c++) begin
        logic [15:0] ev;
        ev = 16'($urandom) & 16'h000F;
        ctx_opcode = 8'($urandom);
        ctx_priv = 2'($urandom);
        ctx_iaddr = (c % 7 == 0) ? m_ialo : (c % 7 == 1) ? m_iahi : $urandom_range(0, 64);
        ctx_daddr = (c % 5 == 0) ? m_dahi : (c % 5 == 1) ? m_dalo : $urandom_range(0, 64);
        evt_pulse = ev;
        if (want_count(ev, ctx_opcode, ctx_priv, ctx_iaddr, ctx_daddr)) m_cnt = m_cnt + 1;
        @(posedge clk); #5;
        check("R2/R3/R4/R5/R6 qualified count", bus_rdata, m_cnt);
        @(negedge clk);
      end
      evt_pulse = 0;
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule